// File: doc/BRIEF.md
# PHY LED Rule Engine

This block drives a small set of status LEDs for an Ethernet PHY from the resolved link state and from traffic events. Each LED has its own rule pair. A steady rule picks the link conditions that keep the LED lit: a given link speed, link down, or full or half duplex. A blink rule picks the transmit, receive and error events that start a blink cycle. Each LED also has a force-on bit, a force-blink bit, an enable bit and a polarity bit.

All LEDs share two timing registers: a blink period and an on time within that period. Both are counted in strobes of an external prescaled tick. A global control register gates the whole engine, and a test bit in it makes every clock count as a tick.

Software programs the engine through a plain 16-bit write port with a combinational read-back on the same address. The link status inputs come from the PHY core. Activity and error inputs are one-cycle pulses, given per speed for transmit and receive.

Top module: `phy_led_engine`

## Requirements
- R1: After reset every `led_o` bit is 1, control reads 0x0000, on time reads 0x0400, blink period reads 0x0800, and every rule register reads 0x0000.
- R2: The registers sit at these addresses: control at 0x21, on time at 0x22, blink period at 0x23, steady rule of LED i at 0x24+2i, blink rule of LED i at 0x25+2i. A read returns the stored value with unused bits as zero. Control keeps bits 15 and 3..0, steady rules keep bits 15, 14, 8 and 6..0, blink rules keep bits 11..0, and the durations keep all 16 bits. Control bits 1..0 are stored only.
- R3: A read of any other address returns 0, and a write to any other address changes no register.
- R4: The engine runs only while control bit 3 (clock enable) and bit 15 (external control) are both 1. Otherwise every LED shows its idle level and all blink cycles are cleared. The idle level is the inverse of steady-rule bit 14, where 1 means active high.
- R5: An LED whose steady-rule bit 15 (enable) is 0 shows its idle level.
- R6: Outside a blink cycle, an LED is lit when one of its steady-rule bits holds. Bit 0 is link up at 1000, bit 1 link up at 100, bit 2 link up at 10, bit 8 link up at 2500. Bit 3 is link down, bit 4 link up at full duplex, bit 5 link up at half duplex. Speed code 0 means 10, 1 means 100, 2 means 1000 and 3 means 2500. Codes 4 to 7 match no speed bit.
- R7: Steady-rule bit 6 lights the LED outside a blink cycle whatever the link state.
- R8: Blink-rule bits select events. For TX and RX: 1000 uses bits 0 and 1, 100 uses bits 2 and 3, 10 uses bits 4 and 5, and 2500 uses bits 10 and 11. Bit 6 is collision, bit 7 is CRC error and bit 8 is idle error. A selected event starts or restarts a cycle at count 0. During a cycle the LED is lit while count < on time, whatever its steady rule. Each tick adds one to the count, and the cycle ends on the tick where count+1 >= period.
- R9: Blink-rule bit 9 (force blink) starts a cycle whenever none is running, so cycles repeat without events.
- R10: With control bit 2 set, every clock acts as a tick. With it clear, only `tick_i` strobes advance a cycle.
- R11: `led_o` is registered. It reflects the inputs and register values present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled timing strobe |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register address for write and read |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data for `cfg_addr_i` (combinational) |
| link_up_i | input | 1 | Link is up |
| speed_i | input | 3 | Resolved speed code |
| full_dup_i | input | 1 | Link is full duplex |
| tx_act_i | input | 4 | Transmit pulses, index 0..3 = 10/100/1000/2500 |
| rx_act_i | input | 4 | Receive pulses, same indexing |
| collision_i | input | 1 | Collision pulse |
| crc_err_i | input | 1 | Receive CRC error pulse |
| idle_err_i | input | 1 | Receive idle error pulse |
| led_o | output | 3 | LED drive, one bit per LED |

## Verification
The hardest situation to reach is an event that restarts a blink cycle already under way. The same applies to a force-blink cycle that wraps while the engine is gated off, or while the period is shorter than the on time. All of these depend on where the count sits when the next event or tick arrives. Directed phases set up short periods and single-cycle pulses at chosen offsets into a cycle. A long random phase then mixes sparse events, random tick strobes and register rewrites in the middle of a cycle. A cycle-level reference model in the bench tracks the expected output on every clock.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    localparam int DW = 16;
    localparam int AW = 8;

    localparam logic [AW-1:0] ADR_CTRL   = 8'h21;
    localparam logic [AW-1:0] ADR_ON_T   = 8'h22;
    localparam logic [AW-1:0] ADR_PERIOD = 8'h23;
    localparam logic [AW-1:0] ADR_RULES  = 8'h24;

    localparam logic [DW-1:0] CTRL_KEEP   = 16'h800F;
    localparam logic [DW-1:0] STEADY_KEEP = 16'hC17F;
    localparam logic [DW-1:0] BLINK_KEEP  = 16'h0FFF;

    // control bits
    localparam int C_TTEST = 2;
    localparam int C_CLKEN = 3;
    localparam int C_EXT   = 15;

    // steady-rule bits
    localparam int S_LDOWN = 3;
    localparam int S_FDX   = 4;
    localparam int S_HDX   = 5;
    localparam int S_FORCE = 6;
    localparam int S_POL   = 14;
    localparam int S_EN    = 15;

    // blink-rule bits
    localparam int B_COL   = 6;
    localparam int B_CRC   = 7;
    localparam int B_IDLE  = 8;
    localparam int B_FORCE = 9;

    localparam int NSPD = 4;
    // indexed by speed code 0..3 = 10/100/1000/2500
    localparam int SPD_STEADY_BIT [NSPD] = '{2, 1, 0, 8};
    localparam int SPD_TX_BIT     [NSPD] = '{4, 2, 0, 10};
    localparam int SPD_RX_BIT     [NSPD] = '{5, 3, 1, 11};

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] on_t;
        logic [DW-1:0] period;
    } glob_cfg_t;

    typedef struct packed {
        logic [DW-1:0] steady;
        logic [DW-1:0] blink;
    } led_cfg_t;

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import phy_led_pkg::*;
#(
    parameter int            N_LED     = 3,
    parameter logic [DW-1:0] RST_ON_T  = 16'h0400,
    parameter logic [DW-1:0] RST_PER   = 16'h0800
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output glob_cfg_t             glob_o,
    output led_cfg_t [N_LED-1:0]  led_o
);

    typedef struct packed {
        glob_cfg_t             g;
        led_cfg_t [N_LED-1:0]  l;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            if (addr_i == ADR_CTRL)   regs_d.g.ctrl   = wdata_i & CTRL_KEEP;
            if (addr_i == ADR_ON_T)   regs_d.g.on_t   = wdata_i;
            if (addr_i == ADR_PERIOD) regs_d.g.period = wdata_i;
            for (int i = 0; i < N_LED; i++) begin
                if (addr_i == ADR_RULES + AW'(2 * i))
                    regs_d.l[i].steady = wdata_i & STEADY_KEEP;
                if (addr_i == ADR_RULES + AW'(2 * i + 1))
                    regs_d.l[i].blink = wdata_i & BLINK_KEEP;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.g.ctrl   <= '0;
            regs_q.g.on_t   <= RST_ON_T;
            regs_q.g.period <= RST_PER;
            regs_q.l        <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADR_CTRL)   rdata_o = regs_q.g.ctrl;
        if (addr_i == ADR_ON_T)   rdata_o = regs_q.g.on_t;
        if (addr_i == ADR_PERIOD) rdata_o = regs_q.g.period;
        for (int i = 0; i < N_LED; i++) begin
            if (addr_i == ADR_RULES + AW'(2 * i))     rdata_o = regs_q.l[i].steady;
            if (addr_i == ADR_RULES + AW'(2 * i + 1)) rdata_o = regs_q.l[i].blink;
        end
    end

    assign glob_o = regs_q.g;
    assign led_o  = regs_q.l;

endmodule

// File: rtl/led_rule_decode.sv
module led_rule_decode
    import phy_led_pkg::*;
(
    input  led_cfg_t         cfg_i,
    input  logic             link_up_i,
    input  logic [2:0]       speed_i,
    input  logic             full_dup_i,
    input  logic [NSPD-1:0]  tx_act_i,
    input  logic [NSPD-1:0]  rx_act_i,
    input  logic             collision_i,
    input  logic             crc_err_i,
    input  logic             idle_err_i,
    output logic             steady_hit_o,
    output logic             event_hit_o
);

    always_comb begin
        steady_hit_o = (!link_up_i && cfg_i.steady[S_LDOWN])
                     || (link_up_i &&  full_dup_i && cfg_i.steady[S_FDX])
                     || (link_up_i && !full_dup_i && cfg_i.steady[S_HDX]);
        for (int s = 0; s < NSPD; s++) begin
            if (link_up_i && (speed_i == 3'(s)) && cfg_i.steady[SPD_STEADY_BIT[s]])
                steady_hit_o = 1'b1;
        end
    end

    always_comb begin
        event_hit_o = (collision_i && cfg_i.blink[B_COL])
                    || (crc_err_i  && cfg_i.blink[B_CRC])
                    || (idle_err_i && cfg_i.blink[B_IDLE]);
        for (int s = 0; s < NSPD; s++) begin
            if ((tx_act_i[s] && cfg_i.blink[SPD_TX_BIT[s]])
                || (rx_act_i[s] && cfg_i.blink[SPD_RX_BIT[s]]))
                event_hit_o = 1'b1;
        end
    end

endmodule

// File: rtl/led_channel.sv
module led_channel
    import phy_led_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           eng_on_i,
    input  logic           tick_i,
    input  logic [DW-1:0]  on_t_i,
    input  logic [DW-1:0]  period_i,
    input  led_cfg_t       cfg_i,
    input  logic           steady_hit_i,
    input  logic           event_hit_i,
    output logic           led_o
);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] cnt;
        logic          led;
    } chan_t;

    chan_t st_d, st_q;

    logic        lit;
    logic [DW:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;

        // blink window overrides the steady decision
        if (st_q.run) lit = (st_q.cnt < on_t_i);
        else          lit = cfg_i.steady[S_FORCE] || steady_hit_i;

        st_d.led = (eng_on_i && cfg_i.steady[S_EN] && lit)
                 ? cfg_i.steady[S_POL] : ~cfg_i.steady[S_POL];

        if (!eng_on_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (event_hit_i || (cfg_i.blink[B_FORCE] && !st_q.run)) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run && tick_i) begin
            if (cnt_inc >= {1'b0, period_i}) begin
                st_d.cnt = '0;
                st_d.run = cfg_i.blink[B_FORCE];
            end else begin
                st_d.cnt = cnt_inc[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.run <= 1'b0;
            st_q.cnt <= '0;
            st_q.led <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_o = st_q.led;

endmodule

// File: rtl/phy_led_engine.sv
module phy_led_engine
    import phy_led_pkg::*;
#(
    parameter int            N_LED    = 3,
    parameter logic [DW-1:0] RST_ON_T = 16'h0400,
    parameter logic [DW-1:0] RST_PER  = 16'h0800
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cfg_wr_i,
    input  logic [7:0]        cfg_addr_i,
    input  logic [15:0]       cfg_wdata_i,
    output logic [15:0]       cfg_rdata_o,
    input  logic              link_up_i,
    input  logic [2:0]        speed_i,
    input  logic              full_dup_i,
    input  logic [3:0]        tx_act_i,
    input  logic [3:0]        rx_act_i,
    input  logic              collision_i,
    input  logic              crc_err_i,
    input  logic              idle_err_i,
    output logic [N_LED-1:0]  led_o
);

    glob_cfg_t             glob;
    led_cfg_t [N_LED-1:0]  lcfg;
    logic                  eng_on;
    logic                  tick_eff;

    logic [DW-1:0]              ctrl_w;
    logic [N_LED-1:0][DW-1:0]   steady_w;

    led_cfg_regs #(
        .N_LED    (N_LED),
        .RST_ON_T (RST_ON_T),
        .RST_PER  (RST_PER)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .glob_o  (glob),
        .led_o   (lcfg)
    );

    assign eng_on   = glob.ctrl[C_CLKEN] && glob.ctrl[C_EXT];
    assign tick_eff = eng_on && (tick_i || glob.ctrl[C_TTEST]);
    assign ctrl_w   = glob.ctrl;

    for (genvar g = 0; g < N_LED; g++) begin : g_led
        logic steady_hit;
        logic event_hit;

        assign steady_w[g] = lcfg[g].steady;

        led_rule_decode dec_i (
            .cfg_i        (lcfg[g]),
            .link_up_i    (link_up_i),
            .speed_i      (speed_i),
            .full_dup_i   (full_dup_i),
            .tx_act_i     (tx_act_i),
            .rx_act_i     (rx_act_i),
            .collision_i  (collision_i),
            .crc_err_i    (crc_err_i),
            .idle_err_i   (idle_err_i),
            .steady_hit_o (steady_hit),
            .event_hit_o  (event_hit)
        );

        led_channel chan_i (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .eng_on_i     (eng_on),
            .tick_i       (tick_eff),
            .on_t_i       (glob.on_t),
            .period_i     (glob.period),
            .cfg_i        (lcfg[g]),
            .steady_hit_i (steady_hit),
            .event_hit_i  (event_hit),
            .led_o        (led_o[g])
        );
    end

endmodule

// File: rtl/phy_led_engine_chk.sv
module phy_led_engine_chk #(
    parameter int N_LED = 3
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   cfg_wr_i,
    input logic [7:0]             cfg_addr_i,
    input logic [15:0]            cfg_wdata_i,
    input logic [15:0]            cfg_rdata_o,
    input logic [N_LED-1:0]       led_o,
    input logic [15:0]            ctrl_i,
    input logic [N_LED-1:0][15:0] steady_i
);

    localparam logic [7:0] TOP_ADR = 8'h23 + 8'(2 * N_LED);

    logic [N_LED-1:0] pol_v;
    always_comb begin
        for (int i = 0; i < N_LED; i++) pol_v[i] = steady_i[i][14];
    end

    // R4
    gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctrl_i[3] && ctrl_i[15]) |=> (led_o == ~$past(pol_v)));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_addr_i < 8'h21 || cfg_addr_i > TOP_ADR) |-> (cfg_rdata_o == 16'h0000));

    // R2
    ctrl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && cfg_addr_i == 8'h21) |=> (ctrl_i == ($past(cfg_wdata_i) & 16'h800F)));

    // R2
    ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_addr_i == 8'h21) |-> (cfg_rdata_o == ctrl_i));

    for (genvar g = 0; g < N_LED; g++) begin : g_chk
        // R5
        led_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !steady_i[g][15] |=> (led_o[g] == ~$past(steady_i[g][14])));
    end

endmodule

bind phy_led_engine phy_led_engine_chk #(.N_LED(N_LED)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .led_o       (led_o),
    .ctrl_i      (ctrl_w),
    .steady_i    (steady_w)
);

// File: tb/phy_led_engine_tb_top.sv
module phy_led_engine_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NL = 3;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [7:0]  cfg_addr_i = 8'h00;
    logic [15:0] cfg_wdata_i = 16'h0;
    logic [15:0] cfg_rdata_o;
    logic        link_up_i = 1'b0;
    logic [2:0]  speed_i = 3'd0;
    logic        full_dup_i = 1'b0;
    logic [3:0]  tx_act_i = 4'h0;
    logic [3:0]  rx_act_i = 4'h0;
    logic        collision_i = 1'b0;
    logic        crc_err_i = 1'b0;
    logic        idle_err_i = 1'b0;
    logic [NL-1:0] led_o;

    always #2.5 clk_i = ~clk_i;

    phy_led_engine dut_i (
        .clk_i, .rst_ni, .tick_i, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i,
        .cfg_rdata_o, .link_up_i, .speed_i, .full_dup_i, .tx_act_i,
        .rx_act_i, .collision_i, .crc_err_i, .idle_err_i, .led_o
    );

    int    total = 0;
    int    bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model, written from the requirements
    logic [15:0] m_ctrl, m_on, m_per;
    logic [15:0] m_st [NL];
    logic [15:0] m_bl [NL];
    logic        m_run [NL];
    logic [15:0] m_cnt [NL];
    logic [NL-1:0] m_led;

    function automatic bit f_steady(input logic [15:0] r, input logic lk,
                                    input logic [2:0] sp, input logic fd);
        bit h;
        h = (!lk && r[3]) || (lk && fd && r[4]) || (lk && !fd && r[5]);
        if (lk && sp == 3'd2 && r[0]) h = 1;
        if (lk && sp == 3'd1 && r[1]) h = 1;
        if (lk && sp == 3'd0 && r[2]) h = 1;
        if (lk && sp == 3'd3 && r[8]) h = 1;
        return h;
    endfunction

    function automatic bit f_event(input logic [15:0] b, input logic [3:0] tx,
                                   input logic [3:0] rx, input logic co,
                                   input logic cr, input logic id);
        return (tx[2] && b[0]) || (rx[2] && b[1]) || (tx[1] && b[2]) ||
               (rx[1] && b[3]) || (tx[0] && b[4]) || (rx[0] && b[5]) ||
               (co && b[6]) || (cr && b[7]) || (id && b[8]) ||
               (tx[3] && b[10]) || (rx[3] && b[11]);
    endfunction

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_ctrl <= 16'h0; m_on <= 16'h0400; m_per <= 16'h0800;
            m_led  <= '1;
            for (int i = 0; i < NL; i++) begin
                m_st[i] <= 16'h0; m_bl[i] <= 16'h0; m_run[i] <= 1'b0; m_cnt[i] <= 16'h0;
            end
        end else begin
            bit act, teff, lit, ev;
            act  = m_ctrl[3] && m_ctrl[15];
            teff = act && (tick_i || m_ctrl[2]);
            for (int i = 0; i < NL; i++) begin
                if (m_run[i]) lit = (m_cnt[i] < m_on);
                else lit = m_st[i][6] || f_steady(m_st[i], link_up_i, speed_i, full_dup_i);
                m_led[i] <= (act && m_st[i][15] && lit) ? m_st[i][14] : ~m_st[i][14];
                ev = f_event(m_bl[i], tx_act_i, rx_act_i, collision_i, crc_err_i, idle_err_i);
                if (!act) begin
                    m_run[i] <= 1'b0; m_cnt[i] <= 16'h0;
                end else if (ev || (m_bl[i][9] && !m_run[i])) begin
                    m_run[i] <= 1'b1; m_cnt[i] <= 16'h0;
                end else if (m_run[i] && teff) begin
                    if (32'(m_cnt[i]) + 1 >= 32'(m_per)) begin
                        m_cnt[i] <= 16'h0; m_run[i] <= m_bl[i][9];
                    end else begin
                        m_cnt[i] <= m_cnt[i] + 16'h1;
                    end
                end
            end
            if (cfg_wr_i) begin
                if (cfg_addr_i == 8'h21) m_ctrl <= cfg_wdata_i & 16'h800F;
                if (cfg_addr_i == 8'h22) m_on   <= cfg_wdata_i;
                if (cfg_addr_i == 8'h23) m_per  <= cfg_wdata_i;
                for (int i = 0; i < NL; i++) begin
                    if (cfg_addr_i == 8'(8'h24 + 2 * i)) m_st[i] <= cfg_wdata_i & 16'hC17F;
                    if (cfg_addr_i == 8'(8'h25 + 2 * i)) m_bl[i] <= cfg_wdata_i & 16'h0FFF;
                end
            end
        end
    end

    always @(negedge clk_i) begin
        if (cmp_en && rst_ni && !done)
            chk(led_o == m_led, cur_req, 16'(led_o), 16'(m_led));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk_i);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        @(negedge clk_i);
        cfg_addr_i = a;
        #1;
        chk(cfg_rdata_o == exp, req, cfg_rdata_o, exp);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        bad++;
        total++;
        $display("FAIL watchdog act=%h exp=%h", 16'h1, 16'h0);
        summary();
    end

    initial begin
        int unused;
        unused = $urandom(32'h00C0FFEE);
        repeat (5) @(negedge clk_i);
        rst_ni = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        #1 chk(led_o == 3'b111, "R1 leds", 16'(led_o), 16'h7);
        rd(8'h21, 16'h0000, "R1 ctrl");
        rd(8'h22, 16'h0400, "R1 on time");
        rd(8'h23, 16'h0800, "R1 period");
        rd(8'h24, 16'h0000, "R1 steady0");
        rd(8'h29, 16'h0000, "R1 blink2");

        // R2 masks and addresses
        for (int a = 8'h21; a <= 8'h29; a++) wr(8'(a), 16'hFFFF);
        rd(8'h21, 16'h800F, "R2 ctrl mask");
        rd(8'h22, 16'hFFFF, "R2 on time");
        rd(8'h23, 16'hFFFF, "R2 period");
        for (int i = 0; i < NL; i++) begin
            rd(8'(8'h24 + 2 * i), 16'hC17F, "R2 steady mask");
            rd(8'(8'h25 + 2 * i), 16'h0FFF, "R2 blink mask");
        end
        wr(8'h21, 16'h0003);
        rd(8'h21, 16'h0003, "R2 mode bits stored");
        wr(8'h22, 16'h1234);

        // R3 unmapped addresses
        wr(8'h20, 16'h5555);
        wr(8'h2A, 16'hAAAA);
        wr(8'hFF, 16'h0F0F);
        rd(8'h20, 16'h0000, "R3 read 0x20");
        rd(8'h2A, 16'h0000, "R3 read 0x2A");
        rd(8'h00, 16'h0000, "R3 read 0x00");
        rd(8'h22, 16'h1234, "R3 no side write");
        rd(8'h21, 16'h0003, "R3 ctrl intact");

        // R5: engine gated, then reprogram rules
        cur_req = "R4 R5 gated";
        for (int i = 0; i < NL; i++) wr(8'(8'h25 + 2 * i), 16'h0000);
        wr(8'h24, 16'hC001);   // LED0: en, active high, link 1000
        wr(8'h26, 16'h4008);   // LED1: disabled, link down
        wr(8'h28, 16'h8100);   // LED2: en, active low, link 2500
        wr(8'h22, 16'h0002);
        wr(8'h23, 16'h0006);
        cyc(3);
        chk(led_o == 3'b100, "R4 idle levels", 16'(led_o), 16'h4);
        wr(8'h21, 16'h8008);
        cyc(2);

        // R11 one-cycle latency, R6 speed decode
        cur_req = "R6 steady";
        @(negedge clk_i);
        link_up_i = 1'b1; speed_i = 3'd2; full_dup_i = 1'b1;
        #1 chk(led_o[0] == 1'b0, "R11 before edge", 16'(led_o[0]), 16'h0);
        @(negedge clk_i);
        chk(led_o[0] == 1'b1, "R11 after edge", 16'(led_o[0]), 16'h1);
        chk(led_o[1] == 1'b0, "R5 disabled idle", 16'(led_o[1]), 16'h0);
        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < 2; l++) begin
                @(negedge clk_i);
                speed_i = 3'(s); link_up_i = l[0]; full_dup_i = s[0];
                cyc(2);
            end
        end
        @(negedge clk_i);
        link_up_i = 1'b1; speed_i = 3'd3;
        cyc(2);
        chk(led_o[2] == 1'b0, "R6 2500 active low", 16'(led_o[2]), 16'h0);
        wr(8'h26, 16'hC030);   // LED1 enabled, duplex bits
        @(negedge clk_i); full_dup_i = 1'b0; cyc(3);
        @(negedge clk_i); link_up_i = 1'b0; cyc(3);

        // R7 force on
        cur_req = "R7 force on";
        wr(8'h26, 16'hC040);
        cyc(2);
        chk(led_o[1] == 1'b1, "R7 force on lit", 16'(led_o[1]), 16'h1);

        // R8 blink events with tick every clock
        cur_req = "R8 blink";
        wr(8'h24, 16'hC001);
        wr(8'h25, 16'h0002);   // LED0: RX at 1000
        @(negedge clk_i); link_up_i = 1'b1; speed_i = 3'd2; tick_i = 1'b1;
        cyc(2);
        @(negedge clk_i); rx_act_i = 4'b0100;
        @(negedge clk_i); rx_act_i = 4'b0000;
        cyc(3);
        @(negedge clk_i); rx_act_i = 4'b0100;     // restart mid-cycle
        @(negedge clk_i); rx_act_i = 4'b0000;
        cyc(9);
        @(negedge clk_i); tx_act_i = 4'b0100;     // not selected
        @(negedge clk_i); tx_act_i = 4'b0000;
        cyc(3);
        chk(led_o[0] == 1'b1, "R8 unselected event ignored", 16'(led_o[0]), 16'h1);
        wr(8'h25, 16'h01C0);
        @(negedge clk_i); collision_i = 1'b1;
        @(negedge clk_i); collision_i = 1'b0;
        cyc(8);
        @(negedge clk_i); idle_err_i = 1'b1;
        @(negedge clk_i); idle_err_i = 1'b0;
        cyc(8);
        wr(8'h22, 16'h0009);   // on time above period
        @(negedge clk_i); crc_err_i = 1'b1;
        @(negedge clk_i); crc_err_i = 1'b0;
        cyc(10);
        wr(8'h23, 16'h0000);   // zero period
        @(negedge clk_i); crc_err_i = 1'b1;
        @(negedge clk_i); crc_err_i = 1'b0;
        cyc(4);

        // R9 force blink, R10 tick source
        cur_req = "R9 force blink";
        wr(8'h22, 16'h0001);
        wr(8'h23, 16'h0003);
        wr(8'h29, 16'h0200);
        cyc(20);
        cur_req = "R10 tick source";
        @(negedge clk_i); tick_i = 1'b0;
        cyc(10);
        wr(8'h21, 16'h800C);
        cyc(12);
        wr(8'h21, 16'h8008);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk_i); tick_i = (k % 4 == 0);
        end

        // R4 gate mid-cycle
        cur_req = "R4 gate";
        wr(8'h21, 16'h0008);
        cyc(4);
        wr(8'h21, 16'h8000);
        cyc(4);
        wr(8'h21, 16'h8008);
        cyc(10);

        // random phase
        cur_req = "R6 R7 R8 R9 R10 R4 R5 R11 random";
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk_i);
            cfg_wr_i    = 1'b0;
            link_up_i   = ($urandom % 8) != 0;
            speed_i     = ($urandom % 6 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
            full_dup_i  = ($urandom % 3) != 0;
            tx_act_i    = ($urandom % 12 == 0) ? 4'($urandom) : 4'h0;
            rx_act_i    = ($urandom % 12 == 0) ? 4'($urandom) : 4'h0;
            collision_i = ($urandom % 50 == 0);
            crc_err_i   = ($urandom % 50 == 0);
            idle_err_i  = ($urandom % 50 == 0);
            tick_i      = ($urandom % 3 == 0);
            if ($urandom % 40 == 0) begin
                logic [7:0]  a;
                logic [15:0] d;
                a = 8'(8'h20 + $urandom % 11);
                d = 16'($urandom);
                if (a == 8'h22 || a == 8'h23) d = 16'($urandom % 9);
                if (a == 8'h21) begin
                    case ($urandom % 6)
                        0, 1, 2: d = 16'h8008;
                        3:       d = 16'h800C;
                        4:       d = 16'h0008;
                        default: d = 16'($urandom);
                    endcase
                end
                if ((a == 8'h24 || a == 8'h26 || a == 8'h28) && ($urandom % 4 != 0))
                    d = d | 16'h8000;
                if ((a == 8'h25 || a == 8'h27 || a == 8'h29) && ($urandom % 3 != 0))
                    d = d & 16'hFDFF;
                cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
            end
        end
        @(negedge clk_i);
        cfg_wr_i = 1'b0;
        cyc(4);
        summary();
    end

endmodule